// File: doc/BRIEF.md
# Pipelined DES Key Search Engine

This block hunts for a DES key by brute force over one contiguous slice of the key space. The known plaintext, the ciphertext it should produce and the fixed upper part of the 56-bit key are elaboration parameters. A run-time counter supplies the low `LOW_BITS` key bits, so one configuration covers exactly 2^LOW_BITS candidate keys. The engine has one registered stage per DES round, sixteen in all, and starts one new candidate every clock while it runs.

Each stage carries its candidate key alongside the two data halves. It derives its own round subkey from that key by fixed wiring, so no key schedule storage exists. A result that matches the target raises `found` and latches the key that produced it, which is not the key then entering the pipeline. A match ends issuing. When the whole slice has been issued without a match, `done` rises only after every in-flight candidate has left the pipeline. `start`, `stop` and `clear` control a run, and `keys_tried` reports how many candidates have entered.

Top module: `des_key_search`

## Requirements
- R1: While running with no match recorded and no `stop`, `keys_tried` grows by exactly one on every clock.
- R2: A candidate issued on clock edge E(1+c) after the edge that samples `start` (counter value c, counted from a fresh run) raises `found` after edge E(19+c) and not before. This is a fixed 18-edge latency: input register, sixteen round stages, compare register, found register.
- R3: On a match, `match_key` holds the 56-bit candidate that produced the matching ciphertext, and it stays stable while `found` is high.
- R4: Once `found` is high, no further candidate is issued (`keys_tried` is frozen) and `start` has no effect until `clear`.
- R5: Candidates are {KEY_BASE[55:LOW_BITS], counter}, with the counter running from 0 upward. After a full run without a match, `keys_tried` equals 2^LOW_BITS and `found` stays low.
- R6: `done` rises exactly 19 edges after the edge that issued the last candidate, never together with `found`, and stays high, ignoring `start`, until `clear`.
- R7: `stop` sampled high halts issuing on that edge. A later `start` resumes at the next untried counter value without repeating or skipping any.
- R8: `clear` zeroes `found`, `match_key`, `done` and `keys_tried`, flushes in-flight candidates and makes the next `start` begin at counter value 0.
- R9: After reset, `found`, `done`, `match_key` and `keys_tried` are all zero.
- R10: The datapath computes standard DES. The 56-bit key is the 64-bit DES key with the least significant (parity) bit of every byte removed. With plaintext 64'h0123456789ABCDEF and target 64'h85E813540F0AB405, the engine reports key 56'h12695BC9B7B7F8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin or resume issuing candidates |
| stop | input | 1 | Halt issuing; in-flight candidates still complete |
| clear | input | 1 | Zero results and counter, flush pipeline |
| found | output | 1 | A matching key has been recorded |
| match_key | output | 56 | The candidate that produced the target ciphertext |
| done | output | 1 | Whole slice issued and drained without a match |
| keys_tried | output | LOW_BITS+1 | Number of candidates issued since clear |

## Verification
The hardest state to reach from the ports is a match that arrives while the slice is still being issued, because the pipeline is deep and the matching key must differ from the key entering at that moment. The bench therefore uses a 12-bit slice whose upper bits are set so that the published DES test key sits at counter value 2040. It then checks the edge on which `found` rises, the frozen issue count and the reported key. A second instance, whose slice excludes the key, is stopped and resumed mid-run, and its `done` edge and final count are checked against the drain arithmetic.

// File: rtl/des_search_pkg.sv
package des_search_pkg;

    localparam int KEY_W = 56;
    localparam int ROUNDS = 16;

    typedef struct packed {
        logic              vld;
        logic [KEY_W-1:0]  key;
        logic [31:0]       l;
        logic [31:0]       r;
    } des_stage_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } srch_state_e;

    localparam int ROT_STEP [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

    localparam int PBOX_T [32] = '{16,7,20,21,29,12,28,17,1,15,23,26,5,18,31,10,
                                    2,8,24,14,32,27,3,9,19,13,30,6,22,11,4,25};

    localparam int PC1_T [56] = '{57,49,41,33,25,17,9,1,58,50,42,34,26,18,
                                   10,2,59,51,43,35,27,19,11,3,60,52,44,36,
                                   63,55,47,39,31,23,15,7,62,54,46,38,30,22,
                                   14,6,61,53,45,37,29,21,13,5,28,20,12,4};

    localparam int PC2_T [48] = '{14,17,11,24,1,5,3,28,15,6,21,10,
                                   23,19,12,4,26,8,16,7,27,20,13,2,
                                   41,52,31,37,47,55,30,40,51,45,33,48,
                                   44,49,39,56,34,53,46,42,50,36,29,32};

    localparam int SB1 [64] = '{14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
                                 0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
                                 4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
                                 15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
    localparam int SB2 [64] = '{15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
                                 3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
                                 0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
                                 13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
    localparam int SB3 [64] = '{10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
                                 13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
                                 13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
                                 1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
    localparam int SB4 [64] = '{7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
                                 13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
                                 10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
                                 3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
    localparam int SB5 [64] = '{2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
                                 14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
                                 4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
                                 11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
    localparam int SB6 [64] = '{12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
                                 10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
                                 9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
                                 4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
    localparam int SB7 [64] = '{4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
                                 13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
                                 1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
                                 6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
    localparam int SB8 [64] = '{13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
                                 1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
                                 7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
                                 2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

    // Total left rotation applied to C/D before round rnd (1-based).
    function automatic int cum_shift(int rnd);
        int acc;
        acc = 0;
        for (int i = 0; i < 16; i++) begin
            if (i < rnd) acc = acc + ROT_STEP[i];
        end
        return acc;
    endfunction

    // Source bit (1 = MSB) feeding output position i of the initial permutation.
    function automatic int ip_src(int i);
        int row;
        int col;
        row = i / 8;
        col = i % 8;
        return ((row < 4) ? (58 + 2 * row) : (57 + 2 * (row - 4))) - 8 * col;
    endfunction

    function automatic logic [63:0] ip_perm(logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[63-i] = x[64-ip_src(i)];
        return y;
    endfunction

    function automatic logic [63:0] fp_perm(logic [63:0] x);
        logic [63:0] y;
        for (int i = 0; i < 64; i++) y[64-ip_src(i)] = x[63-i];
        return y;
    endfunction

    function automatic logic [47:0] expand(logic [31:0] r);
        logic [47:0] y;
        int src;
        for (int i = 0; i < 48; i++) begin
            src = ((4 * (i / 6) + (i % 6) + 31) % 32) + 1;
            y[47-i] = r[32-src];
        end
        return y;
    endfunction

    function automatic logic [31:0] pbox(logic [31:0] x);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[31-i] = x[32-PBOX_T[i]];
        return y;
    endfunction

    // PC-1 taken from the 56-bit key with parity bits already removed.
    function automatic logic [55:0] pc1(logic [55:0] k);
        logic [55:0] y;
        int n;
        int cpos;
        for (int i = 0; i < 56; i++) begin
            n = PC1_T[i] - 1;
            cpos = 7 * (n / 8) + (n % 8) + 1;
            y[55-i] = k[56-cpos];
        end
        return y;
    endfunction

    function automatic logic [47:0] pc2(logic [55:0] cd);
        logic [47:0] y;
        for (int i = 0; i < 48; i++) y[47-i] = cd[56-PC2_T[i]];
        return y;
    endfunction

    function automatic logic [27:0] rotl28(logic [27:0] x, int n);
        logic [27:0] y;
        for (int i = 0; i < 28; i++) y[i] = x[(i - n + 56) % 28];
        return y;
    endfunction

    function automatic logic [3:0] sbox(int box, logic [5:0] six);
        logic [5:0] a;
        a = {six[5], six[0], six[4:1]};
        case (box)
            0: return 4'(SB1[a]);
            1: return 4'(SB2[a]);
            2: return 4'(SB3[a]);
            3: return 4'(SB4[a]);
            4: return 4'(SB5[a]);
            5: return 4'(SB6[a]);
            6: return 4'(SB7[a]);
            default: return 4'(SB8[a]);
        endcase
    endfunction

    function automatic logic [31:0] feistel(logic [31:0] r, logic [47:0] k);
        logic [47:0] x;
        logic [31:0] s;
        x = expand(r) ^ k;
        for (int b = 0; b < 8; b++) s[31-4*b -: 4] = sbox(b, x[47-6*b -: 6]);
        return pbox(s);
    endfunction

endpackage

// File: rtl/des_search_round.sv
module des_search_round
    import des_search_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  des_stage_t d_in,
    output des_stage_t d_out
);
    localparam int SHIFT = cum_shift(ROUND);

    logic [55:0] cd_base;
    logic [27:0] c_rot;
    logic [27:0] d_rot;
    logic [47:0] subkey;

    assign cd_base = pc1(d_in.key);
    assign c_rot   = rotl28(cd_base[55:28], SHIFT);
    assign d_rot   = rotl28(cd_base[27:0], SHIFT);
    assign subkey  = pc2({c_rot, d_rot});

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            d_out <= '0;
        end else begin
            d_out.vld <= d_in.vld;
            d_out.key <= d_in.key;
            d_out.l   <= d_in.r;
            d_out.r   <= d_in.l ^ feistel(d_in.r, subkey);
        end
    end
endmodule

// File: rtl/des_search_pipe.sv
module des_search_pipe
    import des_search_pkg::*;
#(
    parameter logic [63:0] PLAIN  = 64'h0123456789ABCDEF,
    parameter logic [63:0] TARGET = 64'h85E813540F0AB405
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_vld,
    input  logic [KEY_W-1:0] in_key,
    output logic             hit_vld,
    output logic             hit_match,
    output logic [KEY_W-1:0] hit_key,
    output logic             busy
);
    localparam logic [63:0] PT_IP = ip_perm(PLAIN);

    des_stage_t head;
    des_stage_t stg [ROUNDS+1];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head <= '0;
        end else begin
            head.vld <= in_vld;
            head.key <= in_key;
            head.l   <= PT_IP[63:32];
            head.r   <= PT_IP[31:0];
        end
    end

    assign stg[0] = head;

    for (genvar g = 0; g < ROUNDS; g++) begin : g_round
        des_search_round #(.ROUND(g + 1)) u_round (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .d_in  (stg[g]),
            .d_out (stg[g+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hit_vld   <= 1'b0;
            hit_match <= 1'b0;
            hit_key   <= '0;
        end else begin
            hit_vld   <= stg[ROUNDS].vld;
            hit_match <= (fp_perm({stg[ROUNDS].r, stg[ROUNDS].l}) == TARGET);
            hit_key   <= stg[ROUNDS].key;
        end
    end

    always_comb begin
        busy = hit_vld;
        for (int i = 0; i <= ROUNDS; i++) busy = busy | stg[i].vld;
    end
endmodule

// File: rtl/des_search_ctrl.sv
module des_search_ctrl
    import des_search_pkg::*;
#(
    parameter int               LOW_BITS = 12,
    parameter logic [KEY_W-1:0] KEY_BASE = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                stop,
    input  logic                clear,
    input  logic                hit_vld,
    input  logic                hit_match,
    input  logic [KEY_W-1:0]    hit_key,
    input  logic                busy,
    output logic                issue_vld,
    output logic [KEY_W-1:0]    issue_key,
    output logic                found,
    output logic [KEY_W-1:0]    match_key,
    output logic                done,
    output logic [LOW_BITS:0]   tried
);
    localparam logic [LOW_BITS-1:0] LAST = '1;

    srch_state_e         state;
    logic [LOW_BITS-1:0] cnt;

    assign issue_vld = (state == ST_RUN) && !found && !stop && !clear;
    assign issue_key = {KEY_BASE[KEY_W-1:LOW_BITS], cnt};
    assign done      = (state == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            found     <= 1'b0;
            match_key <= '0;
        end else if (hit_vld && hit_match && !found) begin
            found     <= 1'b1;
            match_key <= hit_key;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tried <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start && !found) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (issue_vld) begin
                        cnt   <= cnt + 1'b1;
                        tried <= tried + 1'b1;
                        if (cnt == LAST) state <= ST_DRAIN;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (found)      state <= ST_IDLE;
                    else if (!busy) state <= ST_DONE;
                end
                default: state <= ST_DONE;
            endcase
        end
    end
endmodule

// File: rtl/des_key_search.sv
module des_key_search
    import des_search_pkg::*;
#(
    parameter int               LOW_BITS = 12,
    parameter logic [KEY_W-1:0] KEY_BASE = 56'h12695BC9B7B000,
    parameter logic [63:0]      PLAIN    = 64'h0123456789ABCDEF,
    parameter logic [63:0]      TARGET   = 64'h85E813540F0AB405
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              clear,
    output logic              found,
    output logic [55:0]       match_key,
    output logic              done,
    output logic [LOW_BITS:0] keys_tried
);
    logic             issue_vld;
    logic [KEY_W-1:0] issue_key;
    logic             hit_vld;
    logic             hit_match;
    logic [KEY_W-1:0] hit_key;
    logic             busy;

    des_search_ctrl #(.LOW_BITS(LOW_BITS), .KEY_BASE(KEY_BASE)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .clear     (clear),
        .hit_vld   (hit_vld),
        .hit_match (hit_match),
        .hit_key   (hit_key),
        .busy      (busy),
        .issue_vld (issue_vld),
        .issue_key (issue_key),
        .found     (found),
        .match_key (match_key),
        .done      (done),
        .tried     (keys_tried)
    );

    des_search_pipe #(.PLAIN(PLAIN), .TARGET(TARGET)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .flush     (clear),
        .in_vld    (issue_vld),
        .in_key    (issue_key),
        .hit_vld   (hit_vld),
        .hit_match (hit_match),
        .hit_key   (hit_key),
        .busy      (busy)
    );
endmodule

// File: rtl/des_key_search_chk.sv
module des_key_search_chk #(
    parameter int LOW_BITS = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              clear,
    input logic              found,
    input logic [55:0]       match_key,
    input logic              done,
    input logic [LOW_BITS:0] keys_tried
);
    localparam logic [LOW_BITS:0] FULL = {1'b1, {LOW_BITS{1'b0}}};

    // R1
    tried_step_chk: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (keys_tried == $past(keys_tried)) || (keys_tried == $past(keys_tried) + 1'b1));

    // R4
    found_hold_chk: assert property (@(posedge clk) disable iff (rst)
        found && !clear |=> found);

    // R3
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        found && !clear |=> $stable(match_key));

    // R4
    halt_after_found_chk: assert property (@(posedge clk) disable iff (rst)
        found && !clear |=> $stable(keys_tried));

    // R6
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !found);

    // R5
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> keys_tried == FULL);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !found && !done && keys_tried == '0 && match_key == '0);
endmodule

bind des_key_search des_key_search_chk #(.LOW_BITS(LOW_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clear      (clear),
    .found      (found),
    .match_key  (match_key),
    .done       (done),
    .keys_tried (keys_tried)
);

// File: tb/des_key_search_tb.sv
module des_key_search_tb;
    localparam int A_BITS = 12;
    localparam int B_BITS = 8;
    localparam logic [55:0] GOOD_KEY = 56'h12695BC9B7B7F8;
    localparam int A_HIT = 2040;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_start = 1'b0, a_stop = 1'b0, a_clear = 1'b0;
    logic b_start = 1'b0, b_stop = 1'b0, b_clear = 1'b0;

    logic              a_found, a_done;
    logic [55:0]       a_key;
    logic [A_BITS:0]   a_tried;
    logic              b_found, b_done;
    logic [55:0]       b_key;
    logic [B_BITS:0]   b_tried;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    des_key_search #(.LOW_BITS(A_BITS), .KEY_BASE(56'h12695BC9B7B000)) u_dut (
        .clk(clk), .rst(rst), .start(a_start), .stop(a_stop), .clear(a_clear),
        .found(a_found), .match_key(a_key), .done(a_done), .keys_tried(a_tried)
    );

    des_key_search #(.LOW_BITS(B_BITS), .KEY_BASE(56'h92695BC9B7B700)) u_dut_b (
        .clk(clk), .rst(rst), .start(b_start), .stop(b_stop), .clear(b_clear),
        .found(b_found), .match_key(b_key), .done(b_done), .keys_tried(b_tried)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R9 reset state
        chk("R9 found", 64'(a_found), 64'd0);
        chk("R9 done", 64'(a_done), 64'd0);
        chk("R9 key", 64'(a_key), 64'd0);
        chk("R9 tried", 64'(a_tried), 64'd0);

        // Instance A: match at counter value 2040
        a_start = 1'b1; step(1); a_start = 1'b0;     // after E0
        step(5);
        chk("R1 tried after 5", 64'(a_tried), 64'd5);
        step(A_HIT + 18 - 5);                        // after E(18+c)
        chk("R2 found not yet", 64'(a_found), 64'd0);
        step(1);                                     // after E(19+c)
        chk("R2 found edge", 64'(a_found), 64'd1);
        chk("R3 R10 matched key", 64'(a_key), 64'(GOOD_KEY));
        chk("R4 tried frozen at hit", 64'(a_tried), 64'(A_HIT + 19));
        step(20);
        chk("R4 still found", 64'(a_found), 64'd1);
        chk("R4 tried unchanged", 64'(a_tried), 64'(A_HIT + 19));
        chk("R6 no done after match", 64'(a_done), 64'd0);
        a_start = 1'b1; step(1); a_start = 1'b0;
        step(5);
        chk("R4 start ignored", 64'(a_tried), 64'(A_HIT + 19));
        chk("R3 key stable", 64'(a_key), 64'(GOOD_KEY));

        a_clear = 1'b1; step(1); a_clear = 1'b0;
        chk("R8 found cleared", 64'(a_found), 64'd0);
        chk("R8 key cleared", 64'(a_key), 64'd0);
        chk("R8 tried cleared", 64'(a_tried), 64'd0);
        chk("R8 done cleared", 64'(a_done), 64'd0);
        a_start = 1'b1; step(1); a_start = 1'b0;
        step(A_HIT + 18);
        chk("R8 restart found not yet", 64'(a_found), 64'd0);
        step(1);
        chk("R8 restart found from zero", 64'(a_found), 64'd1);
        chk("R8 restart key", 64'(a_key), 64'(GOOD_KEY));

        // Instance B: slice without the key, stopped and resumed
        b_start = 1'b1; step(1); b_start = 1'b0;
        step(5);
        chk("R1 B tried after 5", 64'(b_tried), 64'd5);
        step(4);
        chk("R1 B tried after 9", 64'(b_tried), 64'd9);
        b_stop = 1'b1; step(1); b_stop = 1'b0;
        chk("R7 stop halts on its edge", 64'(b_tried), 64'd9);
        step(10);
        chk("R7 stays halted", 64'(b_tried), 64'd9);
        chk("R7 no done while halted", 64'(b_done), 64'd0);
        b_start = 1'b1; step(1); b_start = 1'b0;
        step(3);
        chk("R7 resume counts on", 64'(b_tried), 64'd12);
        step(262);                                   // after E'265
        chk("R6 done not before drain", 64'(b_done), 64'd0);
        step(1);                                     // after E'266
        chk("R6 done after drain", 64'(b_done), 64'd1);
        chk("R5 full slice count", 64'(b_tried), 64'd256);
        chk("R5 no false match", 64'(b_found), 64'd0);
        b_start = 1'b1; step(1); b_start = 1'b0;
        step(5);
        chk("R6 done holds", 64'(b_done), 64'd1);
        chk("R6 count holds", 64'(b_tried), 64'd256);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule